// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a processor's 16-bit address bus and two external memories: a large ROM and a smaller banked RAM. The lower half of the processor's address space reads ROM. A fixed 16 KiB window at the bottom always shows the first ROM bank. A second 16 KiB window shows whichever bank is currently selected. An 8 KiB window starting at 0xA000 reaches the RAM, one bank at a time.

Writes into the ROM half of the address space do not reach the ROM. They are decoded as writes to four control registers:

- a RAM enable,
- a 5-bit low bank number,
- a 2-bit high bank field,
- a banking-mode bit.

The mode bit decides where the high field goes. In one mode it extends the ROM bank number. In the other mode it selects the RAM bank.

Address translation is combinational on the current bus address. A register write takes effect on the clock edge that ends the write cycle. Read data from the two memories is steered back to the processor. When RAM is disabled, RAM reads return all ones and RAM writes never reach the RAM.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the RAM is disabled, the mode is ROM banking, the high field is 0 and the low bank number is 1. A read at 0x4000 therefore produces ROM address 0x4000, and a read at 0xA000 returns 0xFF.
- R2: A bus address in 0x0000–0x3FFF produces a ROM address equal to the bus address, whatever the bank registers hold. The returned data is the ROM data input.
- R3: A bus address in 0x4000–0x7FFF produces the ROM address (active ROM bank × 0x4000) + (address − 0x4000). The returned data is the ROM data input.
- R4: A write to 0x0000–0x1FFF with data 0x0A turns RAM on, and one with data 0x00 turns it off. Any other data value leaves the enable as it was.
- R5: A write to 0x2000–0x3FFF stores data bits [4:0] as the low bank number. When those five bits are zero, the value 1 is stored instead. This also applies when bits [7:5] are set, so data 0x20 stores 1.
- R6: A write to 0x4000–0x5FFF stores data bits [1:0] as the high field. Data bits [7:2] are ignored.
- R7: A write to 0x6000–0x7FFF sets the mode from data bit 0, where 0 means ROM banking and 1 means RAM banking. Data bits [7:1] are ignored.
- R8: In ROM banking mode the active ROM bank is high×32 + low, and the active RAM bank is 0.
- R9: In RAM banking mode the active ROM bank is the low bank number alone, and the active RAM bank is the high field.
- R10: A bus address in 0xA000–0xBFFF produces the RAM address (active RAM bank × 0x2000) + (address − 0xA000). The RAM write strobe is high only for a processor write in that window while RAM is on.
- R11: A read in the RAM window returns the RAM data input while RAM is on, and 0xFF while it is off.
- R12: A register write changes the translation from the clock edge that ends the write cycle. A write to any address outside 0x0000–0x7FFF changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | Processor bus address |
| cpuWrData | input | 8 | Processor write data, also forwarded to the RAM |
| cpuWrEn | input | 1 | Processor write strobe for the current cycle |
| romRdData | input | 8 | Data returned by the ROM at romAddr |
| ramRdData | input | 8 | Data returned by the RAM at ramAddr |
| romAddr | output | 21 | Physical ROM byte address |
| ramAddr | output | 15 | Physical RAM byte address |
| ramWrEn | output | 1 | RAM write strobe |
| cpuRdData | output | 8 | Read data steered back to the processor |

## Verification
A wrong low bank number, high field or mode bit shows up in romAddr or ramAddr at the very next bus access to the switchable ROM window or the RAM window. That is one cycle after the write that corrupted it. The bench therefore follows every register write with reads in both windows.

A stuck or wrongly updated RAM enable has two visible effects:

- a RAM-window read returns 0xFF instead of RAM data, or RAM data instead of 0xFF;
- ramWrEn asserts or fails to assert during a write to the RAM window.

Both effects appear in the same cycle as the access.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  // Decoded actions for one bus cycle, from control to datapath.
  typedef struct packed {
    logic ldRamEn;   // load RAM enable with ramEnVal
    logic ramEnVal;  // value for the RAM enable
    logic ldLower;   // load the low bank number
    logic ldUpper;   // load the high field
    logic ldMode;    // load the banking mode
    logic inRamWin;  // address lies in the RAM window
    logic ramWrReq;  // processor write in the RAM window
  } bankStrobe_t;

  typedef enum logic {
    MODE_ROM = 1'b0,
    MODE_RAM = 1'b1
  } bankMode_e;

endpackage

// File: rtl/cart_bank_decode.sv
module cart_bank_decode
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RAM_ON_CODE  = 8'h0A,
  parameter logic [DATA_W-1:0] RAM_OFF_CODE = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              cpuWrEn,
  output bankStrobe_t       strobe
);

  // The top three address bits pick one 8 KiB region.
  localparam int REG_W = 3;
  localparam logic [REG_W-1:0] REGION_ENABLE = 3'd0;
  localparam logic [REG_W-1:0] REGION_LOWER  = 3'd1;
  localparam logic [REG_W-1:0] REGION_UPPER  = 3'd2;
  localparam logic [REG_W-1:0] REGION_MODE   = 3'd3;
  localparam logic [REG_W-1:0] REGION_RAM    = 3'd5;

  logic [REG_W-1:0] region;
  logic             isOnCode;
  logic             isOffCode;

  assign region    = cpuAddr[ADDR_W-1 -: REG_W];
  assign isOnCode  = (cpuWrData == RAM_ON_CODE);
  assign isOffCode = (cpuWrData == RAM_OFF_CODE);

  always_comb begin
    strobe          = '0;
    strobe.inRamWin = (region == REGION_RAM);
    strobe.ramWrReq = cpuWrEn && (region == REGION_RAM);
    strobe.ramEnVal = isOnCode;
    if (cpuWrEn) begin
      unique case (region)
        REGION_ENABLE: strobe.ldRamEn = isOnCode || isOffCode;
        REGION_LOWER:  strobe.ldLower = 1'b1;
        REGION_UPPER:  strobe.ldUpper = 1'b1;
        REGION_MODE:   strobe.ldMode  = 1'b1;
        default:       ;
      endcase
    end
  end

  // R12: at most one register is loaded per cycle.
  p_one_load_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldRamEn, strobe.ldLower, strobe.ldUpper, strobe.ldMode}));

  // R4: a register load from the enable region carries one of the two codes.
  p_enable_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldRamEn |-> (cpuWrData == RAM_ON_CODE || cpuWrData == RAM_OFF_CODE));

endmodule

// File: rtl/cart_bank_datapath.sv
module cart_bank_datapath
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LOWER_W   = 5,
  parameter int UPPER_W   = 2,
  parameter int ROM_OFF_W = 14,
  parameter int RAM_OFF_W = 13,
  localparam int BANK_W     = LOWER_W + UPPER_W,
  localparam int ROM_ADDR_W = ROM_OFF_W + BANK_W,
  localparam int RAM_ADDR_W = RAM_OFF_W + UPPER_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuWrData,
  input  bankStrobe_t           strobe,
  input  logic [DATA_W-1:0]     romRdData,
  input  logic [DATA_W-1:0]     ramRdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramWrEn,
  output logic [DATA_W-1:0]     cpuRdData
);

  localparam logic [LOWER_W-1:0] LOWER_RESET = LOWER_W'(1);

  logic               ramEnQ;
  bankMode_e          modeQ;
  logic [UPPER_W-1:0] upperQ;
  logic [LOWER_W-1:0] lowerQ;

  logic [LOWER_W-1:0] lowerField;
  logic [LOWER_W-1:0] lowerNext;
  logic [BANK_W-1:0]  romBank;
  logic [UPPER_W-1:0] ramBank;
  logic               inSwitch;
  logic               inRom;

  // A zero low bank number is replaced by 1, tested on the masked field.
  assign lowerField = cpuWrData[LOWER_W-1:0];
  assign lowerNext  = (lowerField == '0) ? LOWER_RESET : lowerField;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramEnQ <= 1'b0;
      modeQ  <= MODE_ROM;
      upperQ <= '0;
      lowerQ <= LOWER_RESET;
    end else begin
      if (strobe.ldRamEn) ramEnQ <= strobe.ramEnVal;
      if (strobe.ldLower) lowerQ <= lowerNext;
      if (strobe.ldUpper) upperQ <= cpuWrData[UPPER_W-1:0];
      if (strobe.ldMode)  modeQ  <= bankMode_e'(cpuWrData[0]);
    end
  end

  // The mode decides where the high field goes.
  always_comb begin
    if (modeQ == MODE_RAM) begin
      romBank = {{UPPER_W{1'b0}}, lowerQ};
      ramBank = upperQ;
    end else begin
      romBank = {upperQ, lowerQ};
      ramBank = '0;
    end
  end

  assign inRom    = !cpuAddr[ADDR_W-1];
  assign inSwitch = cpuAddr[ROM_OFF_W];

  assign romAddr = inSwitch ? {romBank, cpuAddr[ROM_OFF_W-1:0]}
                            : {{BANK_W{1'b0}}, cpuAddr[ROM_OFF_W-1:0]};
  assign ramAddr = {ramBank, cpuAddr[RAM_OFF_W-1:0]};
  assign ramWrEn = strobe.ramWrReq && ramEnQ;

  always_comb begin
    if (inRom)                          cpuRdData = romRdData;
    else if (strobe.inRamWin && ramEnQ) cpuRdData = ramRdData;
    else                                cpuRdData = '1;
  end

  // R5: after a low-bank load the stored number is never zero.
  p_lower_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldLower |=> (lowerQ != '0));

  // R4: the RAM enable moves only on an enable load.
  p_enable_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldRamEn |=> (ramEnQ == $past(ramEnQ)));

  // R2: the fixed window always shows bank 0.
  p_fixed_bank_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inRom && !inSwitch) |-> (romAddr[ROM_ADDR_W-1:ROM_OFF_W] == '0));

  // R8: in ROM banking mode the RAM bank is 0.
  p_ram_bank_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_ROM) |-> (ramAddr[RAM_ADDR_W-1:RAM_OFF_W] == '0));

  // R10: no RAM write reaches the RAM while RAM is off.
  p_ram_write_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    ramWrEn |-> (ramEnQ && strobe.inRamWin));

  // R11: a RAM-window read with RAM off returns all ones.
  p_ram_off_ones_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inRamWin && !ramEnQ) |-> (cpuRdData == '1));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int LOWER_W   = 5,
  parameter int UPPER_W   = 2,
  parameter int ROM_OFF_W = 14,
  parameter int RAM_OFF_W = 13,
  localparam int ROM_ADDR_W = ROM_OFF_W + LOWER_W + UPPER_W,
  localparam int RAM_ADDR_W = RAM_OFF_W + UPPER_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuWrData,
  input  logic                  cpuWrEn,
  input  logic [DATA_W-1:0]     romRdData,
  input  logic [DATA_W-1:0]     ramRdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramWrEn,
  output logic [DATA_W-1:0]     cpuRdData
);

  bankStrobe_t strobe;

  cart_bank_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_decode (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .cpuWrEn   (cpuWrEn),
    .strobe    (strobe)
  );

  cart_bank_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LOWER_W   (LOWER_W),
    .UPPER_W   (UPPER_W),
    .ROM_OFF_W (ROM_OFF_W),
    .RAM_OFF_W (RAM_OFF_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .strobe    (strobe),
    .romRdData (romRdData),
    .ramRdData (ramRdData),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramWrEn   (ramWrEn),
    .cpuRdData (cpuRdData)
  );

endmodule

// File: tb/test_cart_bank_ctrl.sv
module test_cart_bank_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuWrEn = 1'b0;
  logic [7:0]  romRdData;
  logic [7:0]  ramRdData;
  logic [20:0] romAddr;
  logic [14:0] ramAddr;
  logic        ramWrEn;
  logic [7:0]  cpuRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Expected register state, kept from the requirements.
  int eLower = 1;
  int eUpper = 0;
  int eMode  = 0;
  bit eEn    = 1'b0;

  always #10 clk = ~clk;

  // Behavioural memories: the data is a fixed function of the address.
  function automatic logic [7:0] romWord(logic [20:0] a);
    return a[7:0] ^ {1'b0, a[20:14]};
  endfunction
  function automatic logic [7:0] ramWord(logic [14:0] a);
    return a[7:0] ^ {a[14:13], 6'h15};
  endfunction

  assign romRdData = romWord(romAddr);
  assign ramRdData = ramWord(ramAddr);

  cart_bank_ctrl i_cart_bank_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .cpuWrEn   (cpuWrEn),
    .romRdData (romRdData),
    .ramRdData (ramRdData),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramWrEn   (ramWrEn),
    .cpuRdData (cpuRdData)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int romBankExp();
    return (eMode == 1) ? eLower : (eUpper * 32 + eLower);
  endfunction
  function automatic int ramBankExp();
    return (eMode == 1) ? eUpper : 0;
  endfunction

  // One write cycle. The model follows R4 to R7 and R12.
  task automatic busWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWrEn = 1'b1;
    @(negedge clk);
    cpuWrEn = 1'b0;
    case (a[15:13])
      3'd0: if (d == 8'h0A) eEn = 1'b1; else if (d == 8'h00) eEn = 1'b0;
      3'd1: eLower = (d[4:0] == 0) ? 1 : int'(d[4:0]);
      3'd2: eUpper = int'(d[1:0]);
      3'd3: eMode  = int'(d[0]);
      default: ;
    endcase
  endtask

  task automatic busRead(logic [15:0] a);
    @(negedge clk);
    cpuAddr = a;
    #5;
  endtask

  // Read in the switchable ROM window and check address and data (R3, R8, R9).
  task automatic checkSwitch(logic [13:0] off, string req);
    logic [20:0] exp;
    busRead(16'h4000 + 16'(off));
    exp = 21'(romBankExp()) * 21'h4000 + 21'(off);
    check({req, " rom switch addr"}, 32'(romAddr), 32'(exp));
    check({req, " rom switch data"}, 32'(cpuRdData), 32'(romWord(exp)));
  endtask

  // Read in the RAM window and check address and data (R10, R11).
  task automatic checkRam(logic [12:0] off, string req);
    logic [14:0] exp;
    busRead(16'hA000 + 16'(off));
    exp = 15'(ramBankExp()) * 15'h2000 + 15'(off);
    check({req, " R10 ram addr"}, 32'(ramAddr), 32'(exp));
    check({req, " R11 ram data"}, 32'(cpuRdData), eEn ? 32'(ramWord(exp)) : 32'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state is visible at the ports.
    busRead(16'h4000);
    check("R1 reset bank", 32'(romAddr), 32'h4000);
    busRead(16'hA000);
    check("R1 reset ram off", 32'(cpuRdData), 32'hFF);
    check("R1 reset ram bank", 32'(ramAddr), 32'h0);

    // R4: enable codes, and other values leave the enable alone.
    busWrite(16'h0000, 8'h0A);
    checkRam(13'h0123, "R4 on");
    busWrite(16'h1FFF, 8'h55);
    checkRam(13'h0124, "R4 other keeps on");
    busWrite(16'h1000, 8'h00);
    checkRam(13'h0125, "R4 off");
    busWrite(16'h0001, 8'h5A);
    checkRam(13'h0126, "R4 other keeps off");

    // R10: the RAM write strobe is gated by the enable and the window.
    @(negedge clk);
    cpuAddr = 16'hA321; cpuWrData = 8'h77; cpuWrEn = 1'b1; #5;
    check("R10 write while off", 32'(ramWrEn), 32'h0);
    @(negedge clk); cpuWrEn = 1'b0;
    busWrite(16'h0000, 8'h0A);
    @(negedge clk);
    cpuAddr = 16'hBFFF; cpuWrData = 8'h77; cpuWrEn = 1'b1; #5;
    check("R10 write while on", 32'(ramWrEn), 32'h1);
    check("R10 write addr", 32'(ramAddr), 32'h1FFF);
    @(negedge clk);
    cpuAddr = 16'h2000; cpuWrData = 8'h03; cpuWrEn = 1'b1; #5;
    check("R10 no strobe outside window", 32'(ramWrEn), 32'h0);
    @(negedge clk); cpuWrEn = 1'b0; eLower = 3;
    checkSwitch(14'h0010, "R12 write takes effect");

    // R12: writes above the ROM half change no register.
    busWrite(16'h8000, 8'h00);
    busWrite(16'hA000, 8'h00);
    busWrite(16'hC000, 8'h1F);
    checkSwitch(14'h0020, "R12 high writes ignored");
    checkRam(13'h0040, "R12 high writes ignored");

    // R5: zero substitution on the masked field.
    busWrite(16'h2000, 8'h20);
    checkSwitch(14'h0000, "R5 0x20 gives 1");
    busWrite(16'h3FFF, 8'h00);
    checkSwitch(14'h3FFF, "R5 0x00 gives 1");
    busWrite(16'h2000, 8'hE7);
    checkSwitch(14'h0001, "R5 high bits dropped");

    // Sweep: every mode, high field and low bank, with the ignored data bits set.
    for (int m = 0; m < 2; m++) begin
      busWrite(16'h6000, 8'hA4 | 8'(m));
      for (int u = 0; u < 4; u++) begin
        busWrite(16'h4000, 8'hB4 | 8'(u));
        for (int l = 0; l < 32; l++) begin
          busWrite(16'h2000, 8'(l) | (((l % 3) == 0) ? 8'h20 : 8'hC0));
          checkSwitch(14'((l * 613 + u * 97) & 16'h3FFF),
                      (m == 1) ? "R9 R7 R6 R5" : "R8 R7 R6 R5");
          checkRam(13'((l * 211 + u) & 16'h1FFF), (m == 1) ? "R9" : "R8");
          busRead(16'(((l * 523) + 7) & 16'h3FFF));
          check("R2 fixed addr", 32'(romAddr), 32'(((l * 523) + 7) & 16'h3FFF));
          check("R2 fixed data", 32'(cpuRdData),
                32'(romWord(21'(((l * 523) + 7) & 16'h3FFF))));
        end
      end
    end

    // R11: RAM off again in RAM banking mode.
    busWrite(16'h0000, 8'h00);
    checkRam(13'h1ABC, "R11 off in ram mode");

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule